// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and a 64K x 8 asynchronous static RAM. It takes one single-byte read or write at a time over a valid/ready request port. It plays out the chip-select, output-enable and write-enable sequence that the RAM needs, and it returns read data with a one-cycle valid strobe. The RAM has an active-low select and an active-high select. The controller keeps the first low and the second high for every access, and it deselects the device between accesses by raising the active-low select.

Every analog limit is a nanosecond parameter. Each one becomes a cycle count: the limit is divided by the clock period, rounded up, and never less than one cycle. A read holds output enable low for the longer of the address-access and output-enable times, then captures the bus on the last cycle of that window. A write releases the shared data bus and keeps output enable high. It then pulls write enable low and waits for the RAM output to go high impedance before driving data. It keeps the data driven for at least the data-overlap time before the end of the pulse, and then gives the RAM its recovery time.

A retention request parks the RAM in its low-power state. In this state the active-low select is held high, or, with a build-time option, the active-high select is held low. When the request is withdrawn, the controller waits out a recovery interval before it accepts another access. The states are IDLE, RD_ACC (output enabled), RD_TAIL (rest of the read cycle), WR_PULSE (write enable low), WR_RECOV (after write enable rises), RET (retention) and RET_RECOV (recovery after retention). The transitions are:
- IDLE to RET on a retention request.
- IDLE to RD_ACC or WR_PULSE when a request is accepted.
- RD_ACC to RD_TAIL, or directly to IDLE when the read window already covers the cycle time.
- RD_TAIL to IDLE.
- WR_PULSE to WR_RECOV, then WR_RECOV to IDLE.
- RET to RET_RECOV when the request drops, then RET_RECOV to IDLE.

Top module: `sram_ctl`

## Requirements
- R1: After reset the RAM is deselected (`mem_ce1_n`=1, `mem_ce2`=1), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only in IDLE with no retention request. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for exactly the read-cycle count (read) or the larger of the write-cycle count and pulse-plus-recovery count (write).
- R3: A read drives `mem_ce1_n`=0, `mem_ce2`=1, `mem_we_n`=1 and `mem_oe_n`=0 for ceil(max(tAA,tOE)/period) cycles. It samples `mem_dq_in` on the last of those cycles and presents it on `rd_data` with `rd_valid` high for exactly the following cycle.
- R4: A write holds `mem_we_n` low with the chip selected and `mem_oe_n` high. The pulse lasts the largest of the pulse-width, address-to-end, select-to-end and (turnaround + data-overlap) counts.
- R5: `mem_dq_oe` is low when `mem_we_n` falls. It rises after max(tWHZ,tOHZ) cycles of the pulse, carries the request's write data on `mem_dq_out`, and stays high until `mem_we_n` rises, giving at least the data-overlap count.
- R6: After `mem_we_n` rises the chip stays selected, with `mem_we_n` high, for at least the write-recovery count before IDLE.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: `mem_addr` does not change during any access.
- R9: In IDLE the RAM is deselected by `mem_ce1_n`=1 with `mem_ce2`=1.
- R10: A retention request seen in IDLE takes priority over a pending access. It parks the RAM with `mem_ce1_n`=1, `mem_ce2`=1 (RET_CE2=0) or `mem_ce1_n`=0, `mem_ce2`=0 (RET_CE2=1), with `req_ready` low.
- R11: When the retention request drops, the parked select levels and `req_ready`=0 last for the recovery count. IDLE follows.
- R12: A retention request raised during an access does not cut the access short. Retention begins only after the access returns to IDLE.
- R13: Each timing limit converts to ceil(limit/period) cycles, with a minimum of one. For example, 98 ns at a 5 ns clock gives 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data strobe, one cycle |
| rd_data | output | DW | Read data |
| ret_req | input | 1 | Retention (low-power) request |
| mem_addr | output | AW | RAM address bus |
| mem_ce1_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DW | Data toward the RAM |
| mem_dq_in | input | DW | Data from the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The hardest situations to reach are retention requests that collide with traffic. One is a retention request that rises in the middle of a write pulse. The other is one that arrives in the same cycle as a new request. The stimulus raises the retention input a few cycles after a write is accepted and holds it across the rest of the write. It also asserts the retention input and a read request together, so the read must wait through retention and recovery. A write issued directly after a read, with the request held valid, exercises the bus turnaround against a behavioural RAM that flags contention, short pulses, short data overlap and short recovery.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACC,
        S_RD_TAIL,
        S_WR_PULSE,
        S_WR_RECOV,
        S_RET,
        S_RET_RECOV
    } ctl_state_t;

    // ceiling of ns / clk_ns, never below one cycle
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/sram_ctl_select.sv
`timescale 1ns/1ps
module sram_ctl_select #(
    parameter bit RET_CE2 = 1'b0
) (
    input  logic access,
    input  logic retain,
    output logic ce1_n,
    output logic ce2
);
    generate
        if (RET_CE2) begin : g_park_ce2
            // retention parks the active-high select low
            assign ce1_n = !(access || retain);
            assign ce2   = !retain;
        end else begin : g_park_ce1
            // retention parks the active-low select high
            assign ce1_n = !access;
            assign ce2   = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int CLK_NS    = 5,
    parameter int T_RC_NS   = 100,
    parameter int T_AA_NS   = 100,
    parameter int T_OE_NS   = 50,
    parameter int T_OHZ_NS  = 35,
    parameter int T_WC_NS   = 100,
    parameter int T_AW_NS   = 80,
    parameter int T_CW_NS   = 80,
    parameter int T_WP_NS   = 70,
    parameter int T_DW_NS   = 40,
    parameter int T_WR_NS   = 5,
    parameter int T_WHZ_NS  = 40,
    parameter int T_REC_NS  = 5000000,
    parameter bit RET_CE2   = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          ret_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);
    // R13: every limit becomes a rounded-up cycle count
    localparam int N_RD    = imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
    localparam int N_RC    = ns2cyc(T_RC_NS, CLK_NS);
    localparam int N_RTAIL = (N_RC > N_RD) ? (N_RC - N_RD) : 0;
    localparam int N_DON   = imax(ns2cyc(T_WHZ_NS, CLK_NS), ns2cyc(T_OHZ_NS, CLK_NS));
    localparam int N_DW    = ns2cyc(T_DW_NS, CLK_NS);
    localparam int N_WPUL  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                  imax(ns2cyc(T_CW_NS, CLK_NS), N_DON + N_DW));
    localparam int N_WC    = ns2cyc(T_WC_NS, CLK_NS);
    localparam int N_WREC  = imax(ns2cyc(T_WR_NS, CLK_NS), (N_WC > N_WPUL) ? (N_WC - N_WPUL) : 0);
    localparam int N_REC   = ns2cyc(T_REC_NS, CLK_NS);
    localparam int N_MAX   = imax(imax(imax(N_RD, N_RTAIL), imax(N_WPUL, N_WREC)), N_REC);
    localparam int CNT_W   = $clog2(N_MAX + 1);
    localparam int DRV_AT  = N_WPUL - N_DON;   // counter value from which data is driven

    ctl_state_t       state, state_nx;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] t_cnt;
    logic             t_last;
    logic             access, retain;
    logic [DW-1:0]    wdata_q;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .cnt      (t_cnt),
        .last     (t_last)
    );

    sram_ctl_select #(.RET_CE2(RET_CE2)) u_select (
        .access (access),
        .retain (retain),
        .ce1_n  (mem_ce1_n),
        .ce2    (mem_ce2)
    );

    // next state and timer loads
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (state)
            S_IDLE: begin
                if (ret_req) begin
                    state_nx = S_RET;
                end else if (req_valid) begin
                    t_load = 1'b1;
                    if (req_write) begin
                        state_nx = S_WR_PULSE;
                        t_val    = CNT_W'(N_WPUL);
                    end else begin
                        state_nx = S_RD_ACC;
                        t_val    = CNT_W'(N_RD);
                    end
                end
            end
            S_RD_ACC: begin
                if (t_last) begin
                    if (N_RTAIL > 0) begin
                        state_nx = S_RD_TAIL;
                        t_load   = 1'b1;
                        t_val    = CNT_W'(N_RTAIL);
                    end else begin
                        state_nx = S_IDLE;
                    end
                end
            end
            S_RD_TAIL:   if (t_last) state_nx = S_IDLE;
            S_WR_PULSE: begin
                if (t_last) begin
                    state_nx = S_WR_RECOV;
                    t_load   = 1'b1;
                    t_val    = CNT_W'(N_WREC);
                end
            end
            S_WR_RECOV:  if (t_last) state_nx = S_IDLE;
            S_RET: begin
                if (!ret_req) begin
                    state_nx = S_RET_RECOV;
                    t_load   = 1'b1;
                    t_val    = CNT_W'(N_REC);
                end
            end
            S_RET_RECOV: if (t_last) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // control outputs
    always_comb begin
        access     = (state == S_RD_ACC) || (state == S_RD_TAIL) ||
                     (state == S_WR_PULSE) || (state == S_WR_RECOV);
        retain     = (state == S_RET) || (state == S_RET_RECOV);
        mem_oe_n   = (state != S_RD_ACC);
        mem_we_n   = (state != S_WR_PULSE);
        mem_dq_oe  = (state == S_WR_PULSE) && (t_cnt <= CNT_W'(DRV_AT));
        mem_dq_out = wdata_q;
        req_ready  = (state == S_IDLE) && !ret_req;
    end

    // request capture and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                mem_addr <= req_addr;
                wdata_q  <= req_wdata;
            end
            rd_valid <= (state == S_RD_ACC) && t_last;
            if ((state == S_RD_ACC) && t_last)
                rd_data <= mem_dq_in;
        end
    end

    assert_no_drive_into_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    assert_write_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n));
    assert_drive_inside_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);
    assert_data_at_pulse_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $past(mem_dq_oe));
    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (access && $past(access)) |-> $stable(mem_addr));
    assert_rdvalid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_ready_blocked_by_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |-> !req_ready);
endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
    // expected counts at a 5 ns clock with the overrides below (R13: 98 ns -> 20)
    localparam int NRD = 20, NRC = 24, NWP = 16, NDON = 8, NWC = 20, NREC = 40;
    localparam int MIN_WP = 14, MIN_DW = 8, MIN_WR = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [15:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_ctl #(.T_RC_NS(120), .T_AA_NS(98), .T_REC_NS(200), .RET_CE2(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ret_req(ret_req),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // behavioural RAM with cycle-based timing checks
    logic [7:0] mem [int];
    function automatic logic [7:0] rd_mem(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    logic ram_sel;
    always @* begin
        ram_sel   = !mem_ce1_n && mem_ce2;
        mem_dq_in = (ram_sel && !mem_oe_n && mem_we_n) ? rd_mem(int'(mem_addr)) : 8'h00;
    end

    int pw = 0, dcyc = 0, rec = 0;
    bit had_write = 0;
    logic [7:0] last_d;
    always @(negedge clk) if (rst_n) begin
        if (ram_sel && !mem_we_n) begin
            if (pw == 0 && had_write) chk(rec >= MIN_WR, "R6 recovery", rec, MIN_WR);
            pw++;
            if (mem_dq_oe) begin dcyc++; last_d = mem_dq_out; end
            else dcyc = 0;
        end else if (pw > 0) begin
            chk(pw >= MIN_WP, "R4 pulse width", pw, MIN_WP);
            chk(dcyc >= MIN_DW, "R5 data overlap", dcyc, MIN_DW);
            mem[int'(mem_addr)] = last_d;
            had_write = 1; rec = 1; pw = 0; dcyc = 0;
            chk(ram_sel, "R6 selected in recovery", ram_sel, 1);
        end else begin
            rec++;
        end
        // R7: never drive against an enabled RAM output
        if (mem_dq_oe && ram_sel && !mem_oe_n && mem_we_n)
            chk(0, "R7 contention", 1, 0);
    end

    // cycle reference model: ph 0 idle, 1 read, 2 write, 3 retention, 4 recovery
    int ph = 0, k = 0;
    logic [15:0] m_addr;
    logic [7:0]  m_wd, m_rd;
    bit rv_due = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; k = 0; rv_due = 0;
        end else begin
            rv_due = 0;
            case (ph)
                0: if (ret_req) begin ph = 3; k = 0; end
                   else if (req_valid) begin
                       ph = req_write ? 2 : 1; k = 0; m_addr = req_addr; m_wd = req_wdata;
                   end
                1: begin
                       if (k == NRD - 1) begin rv_due = 1; m_rd = rd_mem(int'(m_addr)); end
                       k++; if (k == NRC) ph = 0;
                   end
                2: begin k++; if (k == NWC) ph = 0; end
                3: if (!ret_req) begin ph = 4; k = 0; end
                4: begin k++; if (k == NREC) ph = 0; end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        logic e_ce1n, e_ce2, e_oe, e_we, e_doe, e_rdy;
        string cer;
        e_ce1n = 1; e_ce2 = 1; e_oe = 1; e_we = 1; e_doe = 0; e_rdy = 0; cer = "R9 idle select";
        case (ph)
            0: e_rdy = !ret_req;
            1: begin e_ce1n = 0; e_oe = (k >= NRD); cer = "R3 read select"; end
            2: begin e_ce1n = 0; e_we = (k >= NWP); e_doe = (k >= NDON) && (k < NWP);
                     cer = (k < NWP) ? "R4 write select" : "R6 recovery select"; end
            3: begin e_ce1n = 0; e_ce2 = 0; cer = "R10 retention select"; end
            default: begin e_ce1n = 0; e_ce2 = 0; cer = "R11 recovery select"; end
        endcase
        chk(req_ready == e_rdy, (ph == 4) ? "R11 ready" : "R2 ready", req_ready, e_rdy);
        chk(mem_ce1_n == e_ce1n, cer, mem_ce1_n, e_ce1n);
        chk(mem_ce2 == e_ce2, cer, mem_ce2, e_ce2);
        chk(mem_oe_n == e_oe, "R3 oe_n", mem_oe_n, e_oe);
        chk(mem_we_n == e_we, "R4 we_n", mem_we_n, e_we);
        chk(mem_dq_oe == e_doe, "R5 drive enable", mem_dq_oe, e_doe);
        chk(rd_valid == rv_due, "R3 rd_valid", rd_valid, rv_due);
        if (rv_due) chk(rd_data == m_rd, "R3 rd_data", rd_data, m_rd);
        if (ph == 1 || ph == 2) chk(mem_addr == m_addr, "R8 address", mem_addr, m_addr);
        if (e_doe) chk(mem_dq_out == m_wd, "R5 write data", mem_dq_out, m_wd);
    end

    task automatic req(input bit w, input logic [15:0] a, input logic [7:0] d);
        bit acc;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        acc = 0;
        while (!acc) begin
            @(negedge clk); acc = req_ready;
            @(posedge clk); #1;
        end
        req_valid = 0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(mem_ce1_n == 1 && mem_ce2 == 1, "R1 select", {mem_ce1_n, mem_ce2}, 2'b11);
        chk(mem_oe_n == 1 && mem_we_n == 1, "R1 enables", {mem_oe_n, mem_we_n}, 2'b11);
        chk(mem_dq_oe == 0 && rd_valid == 0, "R1 drive/valid", {mem_dq_oe, rd_valid}, 0);
        chk(req_ready == 1, "R1 ready", req_ready, 1);
        @(posedge clk); #1 rst_n = 1;

        req(1, 16'h1234, 8'hA5);
        req(0, 16'h1234, 8'h00);      // back-to-back read after write
        req(1, 16'h0000, 8'h3C);      // write right after a read: turnaround
        req(1, 16'hFFFF, 8'hC3);
        req(0, 16'h0000, 8'h00);
        req(0, 16'hFFFF, 8'h00);
        req(0, 16'h0042, 8'h00);      // never written

        // R12: retention raised during a write waits for the write to finish
        req(1, 16'h0500, 8'h5A);
        repeat (3) @(posedge clk); #1 ret_req = 1;
        repeat (30) @(posedge clk); #1 ret_req = 0;
        req(0, 16'h0500, 8'h00);

        // R10/R11: retention and a read arriving together; retention wins
        ret_req = 1;
        fork
            req(0, 16'h1234, 8'h00);
            begin repeat (6) @(posedge clk); #1 ret_req = 0; end
        join
        repeat (40) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule